// File: doc/BRIEF.md
# Threshold Pulse Finder with Zero Suppression

This block is the front end of one detector channel. It takes a stream of ADC samples that runs without pause and without any external trigger. Every sample goes into a circular buffer, whatever the state of the read side. A reader drains the buffer at up to one sample per clock. Input samples arrive at most every second clock, so the reader has twice the write bandwidth.

The reader compares each sample with a programmable threshold. It forwards a sample only when that sample belongs to a run of at least three consecutive samples above the threshold. Shorter runs are treated as glitches. All sub-threshold data is dropped, which gives lossless zero suppression of the pulses.

Each forwarded pulse begins with a marked first sample. The pulse closes with a one-cycle end strobe that carries the number of samples in the pulse and its peak amplitude. A downstream ready input pauses the read side only. A sticky flag reports when the writer had to overwrite unread data.

Top module: `pulse_zs_top`

## Requirements
- R1: When `in_valid` is high, the sample is written into the buffer on every such clock edge, including while `out_ready` is low. With 2^ADDR_W unread entries already stored, a further write replaces the oldest unread sample and sets `overflow`. `overflow` then stays high until reset. Filling the buffer exactly, without a further write, leaves `overflow` low.
- R2: The comparison with `threshold` is strictly greater-than. A sample equal to the threshold counts as below it.
- R3: A run of one or two above-threshold samples followed by a sample at or below the threshold produces no `out_valid` and no `out_end`.
- R4: When the third consecutive above-threshold sample is read, the block emits every sample of the run from its first crossing, in arrival order. `out_first` is high with the first of these samples only.
- R5: No sample at or below the threshold is ever presented with `out_valid` high.
- R6: A pulse ends at its first sample at or below the threshold. That cycle shows `out_end` high for one cycle, `out_valid` low, `out_count` equal to the number of samples emitted for the pulse, and `out_peak`.
- R7: `out_count` is 10 bits wide and saturates at 1023. A pulse longer than that still emits all of its samples.
- R8: `out_peak` equals the largest sample value of the pulse just ended.
- R9: An `out_ready` that is low at a clock edge stops reading and output at that edge. No `out_valid` or `out_end` follows that edge. The sequence of emitted samples and end strobes is the same as it would be with `out_ready` held high.
- R10: After reset, `out_valid`, `out_first`, `out_end`, `out_count`, `out_peak` and `overflow` are zero, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write and read sides |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new ADC sample is present (at most every second cycle) |
| in_sample | input | 10 | ADC sample value |
| threshold | input | 10 | Discrimination level; change only while acquisition is stopped |
| out_ready | input | 1 | Downstream may take output at this edge; low pauses reading |
| out_valid | output | 1 | `out_sample` carries a pulse sample |
| out_sample | output | 10 | Forwarded pulse sample |
| out_first | output | 1 | Marks the first sample of a pulse |
| out_end | output | 1 | One-cycle strobe closing a pulse |
| out_count | output | 10 | Saturating sample count of the closed pulse |
| out_peak | output | 10 | Largest sample of the closed pulse |
| overflow | output | 1 | Sticky: unread data was overwritten |

## Verification
One sample stream mixes several cases:
- isolated one- and two-sample spikes, which must vanish;
- a sample exactly at the threshold, which separates `>` from `>=`;
- pulses of different lengths and shapes, including full-scale values, which check ordering, first markers, counts and peaks.

The same stream is replayed with `out_ready` toggling. This separates a true read stall from a stall that drops or duplicates data. A long pulse of more than a thousand samples shows where the count saturates. With the reader held off, a buffer filled to exactly its depth and then one sample beyond distinguishes a correct full condition from an off-by-one. The pulse drained afterwards shows which sample was overwritten.

// File: rtl/pulse_zs_pkg.sv
package pulse_zs_pkg;

    localparam int SAMPLE_W_DEF = 10;
    localparam int ADDR_W_DEF   = 10;
    localparam int CNT_W_DEF    = 10;
    localparam int HIT_RUN      = 3;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_FLUSH1 = 2'd1,
        ST_FLUSH2 = 2'd2,
        ST_PULSE  = 2'd3
    } finder_state_t;

endpackage

// File: rtl/pzs_ring.sv
module pzs_ring #(
    parameter int W  = pulse_zs_pkg::SAMPLE_W_DEF,
    parameter int AW = pulse_zs_pkg::ADDR_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         overflow
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         full, drop;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign drop    = wr_en && full && !rd_en;
    assign rd_data = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en || drop) rp <= rp + 1'b1;
            if (drop) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/pzs_finder.sv
module pzs_finder
    import pulse_zs_pkg::*;
#(
    parameter int W  = SAMPLE_W_DEF,
    parameter int CW = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_avail,
    input  logic [W-1:0]  s_data,
    input  logic [W-1:0]  thr,
    input  logic          ready,
    output logic          pop,
    output logic          out_valid,
    output logic [W-1:0]  out_sample,
    output logic          out_first,
    output logic          out_end,
    output logic [CW-1:0] out_count,
    output logic [W-1:0]  out_peak
);
    localparam logic [CW-1:0] CNT_MAX   = '1;
    localparam logic [1:0]    RUN_LAST  = 2'(HIT_RUN - 1);
    localparam logic [CW-1:0] CNT_START = CW'(HIT_RUN);

    finder_state_t st;
    logic [1:0]    run;
    logic [W-1:0]  hold0, hold1, hold2;
    logic [W-1:0]  peak, pk2, pk3;
    logic [CW-1:0] cnt;
    logic          above;

    assign above = s_data > thr;
    assign pop   = ready && s_avail && (st == ST_SEARCH || st == ST_PULSE);

    always_comb begin
        pk2 = (hold0 > hold1) ? hold0 : hold1;
        pk3 = (pk2 > s_data) ? pk2 : s_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_SEARCH;
            run        <= '0;
            hold0      <= '0;
            hold1      <= '0;
            hold2      <= '0;
            peak       <= '0;
            cnt        <= '0;
            out_valid  <= 1'b0;
            out_first  <= 1'b0;
            out_end    <= 1'b0;
            out_sample <= '0;
            out_count  <= '0;
            out_peak   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_end   <= 1'b0;
            if (ready) begin
                case (st)
                    ST_SEARCH: if (s_avail) begin
                        if (!above) begin
                            run <= '0;
                        end else if (run == RUN_LAST) begin
                            out_valid  <= 1'b1;
                            out_first  <= 1'b1;
                            out_sample <= hold0;
                            hold2      <= s_data;
                            cnt        <= CNT_START;
                            peak       <= pk3;
                            run        <= '0;
                            st         <= ST_FLUSH1;
                        end else begin
                            if (run == 2'd0) hold0 <= s_data;
                            else             hold1 <= s_data;
                            run <= run + 2'd1;
                        end
                    end
                    ST_FLUSH1: begin
                        out_valid  <= 1'b1;
                        out_sample <= hold1;
                        st         <= ST_FLUSH2;
                    end
                    ST_FLUSH2: begin
                        out_valid  <= 1'b1;
                        out_sample <= hold2;
                        st         <= ST_PULSE;
                    end
                    ST_PULSE: if (s_avail) begin
                        if (above) begin
                            out_valid  <= 1'b1;
                            out_sample <= s_data;
                            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                            if (s_data > peak) peak <= s_data;
                        end else begin
                            out_end   <= 1'b1;
                            out_count <= cnt;
                            out_peak  <= peak;
                            st        <= ST_SEARCH;
                        end
                    end
                    default: st <= ST_SEARCH;
                endcase
            end
        end
    end
endmodule

// File: rtl/pulse_zs_top.sv
module pulse_zs_top
    import pulse_zs_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int CNT_W    = CNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_first,
    output logic                out_end,
    output logic [CNT_W-1:0]    out_count,
    output logic [SAMPLE_W-1:0] out_peak,
    output logic                overflow
);
    logic                rd_en, buf_empty;
    logic [SAMPLE_W-1:0] rd_data;

    pzs_ring #(.W(SAMPLE_W), .AW(ADDR_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .wr_data  (in_sample),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty    (buf_empty),
        .overflow (overflow)
    );

    pzs_finder #(.W(SAMPLE_W), .CW(CNT_W)) u_find (
        .clk        (clk),
        .rst        (rst),
        .s_avail    (!buf_empty),
        .s_data     (rd_data),
        .thr        (threshold),
        .ready      (out_ready),
        .pop        (rd_en),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_first  (out_first),
        .out_end    (out_end),
        .out_count  (out_count),
        .out_peak   (out_peak)
    );
endmodule

// File: rtl/pzs_checker.sv
module pzs_checker #(
    parameter int W  = 10,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          out_ready,
    input logic          out_valid,
    input logic          out_first,
    input logic          out_end,
    input logic          overflow,
    input logic [W-1:0]  out_sample,
    input logic [W-1:0]  threshold,
    input logic [W-1:0]  out_peak,
    input logic [CW-1:0] out_count
);
    assert_sticky_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_min_run_R3: assert property (@(posedge clk) disable iff (rst)
        out_end |-> out_count >= CW'(3));

    assert_first_is_data_R4: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    assert_only_above_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sample > threshold);

    assert_end_alone_R6: assert property (@(posedge clk) disable iff (rst)
        out_end |-> !out_valid);

    assert_peak_above_R8: assert property (@(posedge clk) disable iff (rst)
        out_end |-> out_peak > threshold);

    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> (!out_valid && !out_end));
endmodule

bind pulse_zs_top pzs_checker #(.W(SAMPLE_W), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_first  (out_first),
    .out_end    (out_end),
    .overflow   (overflow),
    .out_sample (out_sample),
    .threshold  (threshold),
    .out_peak   (out_peak),
    .out_count  (out_count)
);

// File: tb/sim_pulse_zs_top.sv
module sim_pulse_zs_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 10;
    localparam int AW = 4;
    localparam int CW = 10;
    localparam int NT = 24;
    localparam logic [W-1:0] THR = 10'd100;

    // each entry: {forwarded, sample}
    localparam logic [W:0] TBL [NT] = '{
        {1'b0, 10'd50},  {1'b0, 10'd150}, {1'b0, 10'd60},  {1'b0, 10'd120},
        {1'b0, 10'd130}, {1'b0, 10'd100}, {1'b1, 10'd101}, {1'b1, 10'd200},
        {1'b1, 10'd300}, {1'b1, 10'd250}, {1'b0, 10'd100}, {1'b0, 10'd20},
        {1'b1, 10'd500}, {1'b1, 10'd600}, {1'b1, 10'd700}, {1'b0, 10'd0},
        {1'b0, 10'd110}, {1'b0, 10'd90},  {1'b1, 10'd1023},{1'b1, 10'd1023},
        {1'b1, 10'd150}, {1'b0, 10'd5},   {1'b0, 10'd100}, {1'b0, 10'd0}
    };

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
    logic [W-1:0] in_sample = '0, threshold = THR;
    logic out_valid, out_first, out_end, overflow;
    logic [W-1:0] out_sample, out_peak;
    logic [CW-1:0] out_count;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    int rdy_mode = 0;
    bit mon_clr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_zs_top #(.SAMPLE_W(W), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .threshold(threshold), .out_ready(out_ready), .out_valid(out_valid),
        .out_sample(out_sample), .out_first(out_first), .out_end(out_end),
        .out_count(out_count), .out_peak(out_peak), .overflow(overflow)
    );

    // ready pattern: 0 = high, 1 = low one edge in three, 2 = low
    int rcyc = 0;
    always @(posedge clk) begin
        #1;
        rcyc <= rcyc + 1;
        out_ready <= (rdy_mode == 0) ? 1'b1 :
                     (rdy_mode == 2) ? 1'b0 : ((rcyc % 3) != 0);
    end

    // output monitor
    logic [W-1:0]  got_s [64];
    bit            got_f [64];
    logic [CW-1:0] got_c [8];
    logic [W-1:0]  got_p [8];
    int n_s = 0, n_e = 0, n_stall_bad = 0;
    logic [W-1:0] last_s = '0;
    logic rdy_q = 1'b1;
    always @(negedge clk) begin
        if (mon_clr) begin
            n_s <= 0; n_e <= 0; n_stall_bad <= 0;
        end else begin
            if (!rdy_q && (out_valid || out_end)) n_stall_bad <= n_stall_bad + 1;
            if (out_valid) begin
                if (n_s < 64) begin got_s[n_s] <= out_sample; got_f[n_s] <= out_first; end
                last_s <= out_sample;
                n_s <= n_s + 1;
            end
            if (out_end) begin
                if (n_e < 8) begin got_c[n_e] <= out_count; got_p[n_e] <= out_peak; end
                n_e <= n_e + 1;
            end
        end
        rdy_q <= out_ready;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; mon_clr = 1'b1;
        repeat (3) tick();
        rst = 1'b0; mon_clr = 1'b0;
        tick();
    endtask

    task automatic push(input logic [W-1:0] v);
        in_valid = 1'b1; in_sample = v; tick();
        in_valid = 1'b0; tick();
    endtask

    task automatic run_table(input string tag);
        int ex_n, ex_e, rl;
        logic [W-1:0] mx;
        for (int i = 0; i < NT; i++) push(TBL[i][W-1:0]);
        repeat (40) tick();
        ex_n = 0; ex_e = 0; rl = 0; mx = '0;
        for (int i = 0; i < NT; i++) begin
            if (TBL[i][W]) begin
                // R2 R4 R5: kept samples in order, first flagged at the crossing
                check(got_s[ex_n] == TBL[i][W-1:0], {"R4 sample ", tag}, got_s[ex_n], TBL[i][W-1:0]);
                check(got_f[ex_n] == (rl == 0), {"R4 first flag ", tag}, got_f[ex_n], rl == 0);
                ex_n++; rl++;
                if (TBL[i][W-1:0] > mx) mx = TBL[i][W-1:0];
            end else if (rl != 0) begin
                // R6 R8: end strobe with count and peak
                check(got_c[ex_e] == CW'(rl), {"R6 count ", tag}, got_c[ex_e], rl);
                check(got_p[ex_e] == mx, {"R8 peak ", tag}, got_p[ex_e], mx);
                ex_e++; rl = 0; mx = '0;
            end
        end
        // R3 R5: glitches and sub-threshold data are absent
        check(n_s == ex_n, {"R3 R5 sample total ", tag}, n_s, ex_n);
        check(n_e == ex_e, {"R3 R6 pulse total ", tag}, n_e, ex_e);
    endtask

    initial begin
        do_reset();
        // R10 reset state
        check(!out_valid && !out_first && !out_end, "R10 strobes", {out_valid, out_first, out_end}, 0);
        check(out_count == 0 && out_peak == 0, "R10 count/peak", out_count + out_peak, 0);
        check(!overflow, "R10 overflow", overflow, 0);

        // table with ready held high
        rdy_mode = 0;
        run_table("ready high");

        // same table with ready toggling (R9)
        do_reset();
        rdy_mode = 1;
        run_table("R9 stalled");
        check(n_stall_bad == 0, "R9 output after low ready", n_stall_bad, 0);
        rdy_mode = 0;

        // R7 saturation of the count on a long pulse
        do_reset();
        for (int i = 0; i < 1100; i++) push(W'(200 + (i % 500)));
        push(10'd10);
        repeat (20) tick();
        check(n_s == 1100, "R7 all samples of long pulse", n_s, 1100);
        check(n_e == 1, "R7 one end strobe", n_e, 1);
        check(got_c[0] == 10'd1023, "R7 saturated count", got_c[0], 1023);
        check(got_p[0] == 10'd699, "R8 peak of long pulse", got_p[0], 699);

        // R1 fill exactly, then overrun with reader paused
        do_reset();
        rdy_mode = 2;
        repeat (3) tick();
        for (int i = 0; i < 16; i++) push(W'(201 + i));
        check(!overflow, "R1 exact fill leaves overflow low", overflow, 0);
        check(n_s == 0 && n_e == 0, "R9 no output while ready low", n_s + n_e, 0);
        push(10'd217);
        check(overflow, "R1 overflow on overrun", overflow, 1);
        rdy_mode = 0;
        repeat (50) tick();
        push(10'd50);
        repeat (10) tick();
        check(got_s[0] == 10'd202, "R1 oldest sample overwritten", got_s[0], 202);
        check(last_s == 10'd217, "R1 newest sample kept", last_s, 217);
        check(n_e == 1 && got_c[0] == 10'd16, "R1 drained pulse length", got_c[0], 16);
        check(overflow, "R1 overflow sticky", overflow, 1);

        // R10 reset clears the flag
        do_reset();
        check(!overflow, "R10 overflow cleared", overflow, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule